// File: doc/BRIEF.md
# SAR ADC serial host controller

This block is the host side of a four-wire serial link to a successive-approximation converter. Its lines are chip select, serial clock, a host-to-converter data line and a converter-to-host data line, plus the converter's BUSY flag. When a request arrives, the engine lowers chip select and sends an 8-bit command byte, most significant bit first. The command carries the channel number, the single-ended/differential choice and the two power/clock-mode bits. The engine then gathers the 16-bit two's-complement sample and hands it back with a one-cycle valid strobe and the channel number of that request.

A per-request framing bit selects one of two frame lengths. The short framing overlaps conversions: when another request is waiting, its start bit goes out on the same serial clock that returns the previous sample's LSB. Each conversion then costs 24 serial clocks, although a full read-out spans 25. The long framing uses 32 clocks per conversion and drives zeros on the unused tail. A mode code of 10 selects the converter's internal conversion clock. In that case the serial clock stops after the command byte, the engine waits for BUSY to fall and rise again, and then clocks the 16 result bits out.

The serial clock is the system clock divided by a parameter. Host data changes only while the serial clock is low, and returned data is captured on each rising edge.

Top module: `adc_serial_host`

## Requirements
- R1: After reset, chip select is high, the serial clock and data out are low, result_valid_o is low and ready_o is high.
- R2: Command byte bits, sent MSB first and sampled by the converter on rising serial clock edges, are: bit 7 = 1 (start), bits 6:4 = channel, bit 3 = 0, bit 2 = sgl_dif_i (1 = single-ended), bits 1:0 = mode_i. Data out never changes while the serial clock is high.
- R3: Every serial clock high and low phase lasts HALF_DIV system cycles, except that the clock is held low during an internal-clock wait. Whenever chip select is high the serial clock is low.
- R4: For any mode code other than 10, the clock after the command byte carries no data, and result bits D15..D0 are captured on the rising edges of clocks 10 to 25 of the conversion.
- R5: In short framing, a request that is already pending when clock 24 ends starts its command byte on the next clock, so a frame of n overlapped conversions has 24n+1 clocks.
- R6: In short framing with no pending request, one tail clock with data out at 0 follows clock 24, and then chip select rises.
- R7: In long framing, a frame has exactly 32 clocks, and data out is 0 on every clock after the command byte.
- R8: With mode code 10, no serial clock edge occurs after the command byte until BUSY has been seen low and then high. After that, 16 clocks capture D15..D0, for 24 clocks in the frame.
- R9: ready_o is high exactly when no request is pending. start_i is accepted only while ready_o is high and is ignored otherwise.
- R10: Each conversion yields one single-cycle result_valid_o pulse carrying its sample and the requester's channel, in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe |
| ready_o | output | 1 | No request pending; start_i is accepted |
| channel_i | input | 3 | Channel address for the request |
| sgl_dif_i | input | 1 | 1 = single-ended, 0 = differential |
| mode_i | input | 2 | Power/clock mode bits; 10 = internal conversion clock |
| frame32_i | input | 1 | 1 = 32-clock framing, 0 = overlapped 24-clock framing |
| result_o | output | 16 | Two's-complement sample |
| result_channel_o | output | 3 | Channel of the returned sample |
| result_valid_o | output | 1 | One-cycle strobe for result_o |
| cs_n_o | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Command data to the converter |
| sdi_i | input | 1 | Sample data from the converter |
| busy_i | input | 1 | Converter BUSY flag |

## Verification
A bench model of the converter watches the serial lines on the falling system-clock edge. It drives each sample bit one half system cycle after the serial clock falls, so a bit is always stable for the rising edge that captures it. result_valid_o is due one system cycle after the rising edge of the last result clock: clock 25 in external modes, or the 16th read clock after BUSY returns. The bench checks each strobe on the system-clock falling edge where it appears, against the sample the model served for that conversion. Clock counts, zero tails and command bytes are checked per frame when chip select rises, and phase widths are checked at every serial clock fall.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int unsigned CTRL_W     = 8;
  localparam int unsigned RES_W      = 16;
  localparam int unsigned CH_W       = 3;
  localparam int unsigned FRAME_LONG = 32;
  localparam logic [1:0]  MODE_INT   = 2'b10;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_WLO, ST_WHI} state_t;

  typedef struct packed {
    logic [CH_W-1:0] ch;
    logic            sgl;
    logic [1:0]      mode;
    logic            f32;
  } req_t;

  function automatic logic [CTRL_W-1:0] ctrl_byte(req_t r);
    return {1'b1, r.ch, 1'b0, r.sgl, r.mode};
  endfunction
endpackage

// File: rtl/adc_host_tick.sv
module adc_host_tick #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (HALF_DIV <= 1) begin : g_direct
      assign tick_o = rst_ni;
    end else begin : g_count
      localparam int unsigned CW = $clog2(HALF_DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else if (cnt_q == CW'(HALF_DIV - 1)) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == CW'(HALF_DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/adc_host_sync.sv
module adc_host_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{1'b1}};
    else pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end
  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/adc_host_capture.sv
module adc_host_capture #(
  parameter int unsigned RES_W = 16,
  parameter int unsigned CH_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [CH_W-1:0]  arm_ch_i,
  input  logic             sample_i,
  input  logic             sdi_i,
  output logic [RES_W-1:0] result_o,
  output logic [CH_W-1:0]  channel_o,
  output logic             valid_o
);
  localparam int unsigned CNT_W = $clog2(RES_W + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [RES_W-1:0] sh_q;
  logic [CH_W-1:0]  ch_q;
  logic [RES_W-1:0] sh_nxt;

  assign sh_nxt = {sh_q[RES_W-2:0], sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      sh_q      <= '0;
      ch_q      <= '0;
      result_o  <= '0;
      channel_o <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (arm_i) begin
        cnt_q <= CNT_W'(RES_W);
        ch_q  <= arm_ch_i;
      end else if (sample_i && cnt_q != '0) begin
        sh_q  <= sh_nxt;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          result_o  <= sh_nxt;
          channel_o <= ch_q;
          valid_o   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host
  import adc_host_pkg::*;
#(
  parameter int unsigned HALF_DIV    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             ready_o,
  input  logic [CH_W-1:0]  channel_i,
  input  logic             sgl_dif_i,
  input  logic [1:0]       mode_i,
  input  logic             frame32_i,
  output logic [RES_W-1:0] result_o,
  output logic [CH_W-1:0]  result_channel_o,
  output logic             result_valid_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             sdo_o,
  input  logic             sdi_i,
  input  logic             busy_i
);
  localparam int unsigned BIT_W = 6;
  localparam logic [BIT_W-1:0] B_CTRL  = BIT_W'(CTRL_W);
  localparam logic [BIT_W-1:0] B_ARM   = BIT_W'(CTRL_W + 1);
  localparam logic [BIT_W-1:0] B_OVL   = BIT_W'(CTRL_W + RES_W);
  localparam logic [BIT_W-1:0] B_SHORT = BIT_W'(CTRL_W + RES_W + 1);
  localparam logic [BIT_W-1:0] B_LONG  = BIT_W'(FRAME_LONG);

  state_t            st_q;
  logic              sclk_q, cs_n_q, sdo_q, pend_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CTRL_W-1:0] ctrl_q;
  req_t              cur_q, pend_r, req_in;
  logic              tick, busy_s;
  logic              is_int, rise_ev, fall_ev, arm;
  logic [BIT_W-1:0]  last_bit;

  adc_host_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  adc_host_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(busy_i), .q_o(busy_s)
  );

  always_comb begin
    req_in.ch   = channel_i;
    req_in.sgl  = sgl_dif_i;
    req_in.mode = mode_i;
    req_in.f32  = frame32_i;
    is_int   = (cur_q.mode == MODE_INT);
    last_bit = cur_q.f32 ? B_LONG : B_SHORT;
    rise_ev  = tick && (st_q == ST_SHIFT) && !sclk_q;
    fall_ev  = tick && (st_q == ST_SHIFT) && sclk_q;
    arm      = (fall_ev && !is_int && bit_q == B_ARM) ||
               ((st_q == ST_WHI) && tick && busy_s);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sclk_q <= 1'b0;
      cs_n_q <= 1'b1;
      sdo_q  <= 1'b0;
      bit_q  <= '0;
      ctrl_q <= '0;
      cur_q  <= '0;
      pend_r <= '0;
      pend_q <= 1'b0;
    end else begin
      if (start_i && !pend_q) begin
        pend_q <= 1'b1;
        pend_r <= req_in;
      end
      unique case (st_q)
        ST_IDLE: begin
          if (tick && pend_q) begin
            cs_n_q <= 1'b0;
            sdo_q  <= 1'b1;
            bit_q  <= BIT_W'(1);
            cur_q  <= pend_r;
            ctrl_q <= ctrl_byte(pend_r);
            pend_q <= 1'b0;
            st_q   <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
            end else begin
              sclk_q <= 1'b0;
              if (is_int && bit_q == B_CTRL) begin
                sdo_q <= 1'b0;
                st_q  <= ST_WLO;
              end else if ((is_int && bit_q == B_OVL) || (!is_int && bit_q == last_bit)) begin
                cs_n_q <= 1'b1;
                sdo_q  <= 1'b0;
                bit_q  <= '0;
                st_q   <= ST_IDLE;
              end else if (!is_int && !cur_q.f32 && bit_q == B_OVL && pend_q) begin
                // next start bit rides on the LSB clock
                sdo_q  <= 1'b1;
                bit_q  <= BIT_W'(1);
                cur_q  <= pend_r;
                ctrl_q <= ctrl_byte(pend_r);
                pend_q <= 1'b0;
              end else begin
                sdo_q  <= ctrl_q[CTRL_W-2];
                ctrl_q <= ctrl_q << 1;
                bit_q  <= bit_q + 1'b1;
              end
            end
          end
        end
        ST_WLO: if (!busy_s) st_q <= ST_WHI;
        ST_WHI: begin
          if (tick && busy_s) begin
            bit_q <= B_ARM;
            st_q  <= ST_SHIFT;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  adc_host_capture #(.RES_W(RES_W), .CH_W(CH_W)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm), .arm_ch_i(cur_q.ch),
    .sample_i(rise_ev), .sdi_i(sdi_i), .result_o(result_o),
    .channel_o(result_channel_o), .valid_o(result_valid_o)
  );

  assign ready_o = !pend_q;
  assign cs_n_o  = cs_n_q;
  assign sclk_o  = sclk_q;
  assign sdo_o   = sdo_q;
endmodule

// File: rtl/adc_serial_host_chk.sv
module adc_serial_host_chk #(
  parameter int unsigned HALF_DIV = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic ready_o,
  input logic cs_n_o,
  input logic sclk_o,
  input logic sdo_o,
  input logic result_valid_o
);
  logic [15:0] hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_cnt <= '0;
    else hi_cnt <= sclk_o ? hi_cnt + 1'b1 : '0;
  end

  assert_sclk_idle_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sclk_o);

  assert_sclk_high_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> hi_cnt == 16'(HALF_DIV));

  assert_sdo_stable_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));

  assert_accept_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o) |=> !ready_o);

  assert_valid_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);
endmodule

bind adc_serial_host adc_serial_host_chk #(.HALF_DIV(HALF_DIV)) u_chk (.*);

// File: tb/adc_serial_host_test.sv
`timescale 1ns/1ps
module adc_serial_host_test;
  localparam int HALF_DIV = 2;

  logic clk = 0, rst_n = 0;
  logic start = 0, sgl = 0, f32 = 0;
  logic [2:0] ch = 0;
  logic [1:0] md = 0;
  logic din = 0, busy = 1;
  logic ready, rvalid, cs_n, sclk, sdo;
  logic [15:0] res;
  logic [2:0] rch;

  int checks = 0, errors = 0;
  int nreq = 0, ridx = 0, sidx = 0, phase = 0;
  logic [7:0] exp_byte [64];
  logic [2:0] exp_ch [64];
  bit done = 0, overlap_seen = 0;

  always #2 clk = ~clk;

  adc_serial_host #(.HALF_DIV(HALF_DIV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ready_o(ready),
    .channel_i(ch), .sgl_dif_i(sgl), .mode_i(md), .frame32_i(f32),
    .result_o(res), .result_channel_o(rch), .result_valid_o(rvalid),
    .cs_n_o(cs_n), .sclk_o(sclk), .sdo_o(sdo), .sdi_i(din), .busy_i(busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] vfun(input int k);
    case (k)
      0: return 16'h7FFF;
      1: return 16'h8000;
      2: return 16'h0000;
      3: return 16'hFFFF;
      4: return 16'h0001;
      default: return 16'((k * 40503 + 12345) & 32'hFFFF);
    endcase
  endfunction

  // converter model
  int s_st = 0, s_bits = 0, s_dcnt = 0, frises = 0, hi_n = 0, zerr = 0, ierr = 0, btmr = 0;
  logic [7:0] s_byte = 0;
  logic [15:0] s_val = 0;
  logic p_sclk = 0, p_cs = 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk) hi_n++;
      if (!sclk && p_sclk) begin
        chk(hi_n == HALF_DIV, "R3 high phase", hi_n, HALF_DIV);
        hi_n = 0;
      end
      if (s_st == 3) begin
        if (sclk && !p_sclk) ierr++;
        if (btmr > 0) btmr--;
        else begin busy = 1; din = s_val[15]; s_st = 4; s_dcnt = 0; end
      end
      if (sclk && !p_sclk && !cs_n) begin
        frises++;
        case (s_st)
          0: if (sdo) begin
               if (!(frises == 1 || (phase == 0 && frises % 24 == 1))) zerr++;
               s_st = 1; s_bits = 1; s_byte = 8'h01;
             end
          1: begin
               s_byte = {s_byte[6:0], sdo}; s_bits++;
               if (s_bits == 8) begin
                 chk(s_byte == exp_byte[sidx], "R2 command byte", s_byte, exp_byte[sidx]);
                 s_val = vfun(sidx); sidx++;
                 if (s_byte[1:0] == 2'b10) begin s_st = 3; busy = 0; btmr = 40; end
                 else begin s_st = 2; s_dcnt = 0; end
               end
             end
          2: begin s_dcnt++; if (sdo) zerr++; end
          4: begin s_dcnt++; if (sdo) zerr++; end
          default: ;
        endcase
      end
      if (!sclk && p_sclk && !cs_n) begin
        if (s_st == 2 && s_dcnt >= 1) begin
          din = s_val[16 - s_dcnt];
          if (s_dcnt == 16) s_st = 0;
        end else if (s_st == 4 && s_dcnt < 16) din = s_val[15 - s_dcnt];
      end
      if (cs_n && !p_cs) begin
        if (phase == 0) begin
          chk(frises >= 25 && frises % 24 == 1, "R5 R6 frame clocks 24n+1", frises, 25);
          if (frises > 25) overlap_seen = 1;
        end else if (phase == 1) chk(frises == 32, "R7 frame clocks", frises, 32);
        else chk(frises == 24, "R8 frame clocks", frises, 24);
        chk(zerr == 0, "R7 R6 data out zero outside command", zerr, 0);
        chk(ierr == 0, "R8 no clock during busy wait", ierr, 0);
        s_st = 0; frises = 0; zerr = 0; ierr = 0; din = 0; busy = 1;
      end
      if (rvalid) begin
        chk(res == vfun(ridx), "R4 R10 result value", res, vfun(ridx));
        chk(rch == exp_ch[ridx], "R10 result channel", rch, exp_ch[ridx]);
        ridx++;
      end
    end
    p_sclk = sclk; p_cs = cs_n;
  end

  task automatic req(input logic [2:0] c, input logic s, input logic [1:0] m, input logic f);
    @(negedge clk);
    while (!ready) @(negedge clk);
    start = 1; ch = c; sgl = s; md = m; f32 = f;
    exp_byte[nreq] = {1'b1, c, 1'b0, s, m};
    exp_ch[nreq] = c;
    nreq++;
    @(negedge clk);
    chk(!ready, "R9 ready drops on accept", ready, 0);
    start = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(ridx == nreq && cs_n));
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1, "R1 cs_n", cs_n, 1);
    chk(sclk === 1'b0 && sdo === 1'b0, "R1 sclk sdo", {sclk, sdo}, 0);
    chk(rvalid === 1'b0 && ready === 1'b1, "R1 valid ready", {rvalid, ready}, 1);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(cs_n === 1'b1 && ready === 1'b1, "R1 idle after reset", {cs_n, ready}, 3);

    phase = 0;
    req(3'd2, 1'b1, 2'b11, 1'b0);
    wait_idle();

    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 2; s++) begin
        req(3'(c), 1'(s), (c % 2 == 1) ? 2'b00 : 2'b11, 1'b0);
        if (c == 1 && s == 1) begin
          @(negedge clk);
          while (ready) @(negedge clk);
          start = 1; ch = 3'd5; sgl = 0; md = 2'b01; f32 = 1;
          @(negedge clk);
          start = 0;
        end
      end
    wait_idle();
    chk(overlap_seen, "R5 overlapped frame seen", overlap_seen, 1);

    phase = 1;
    for (int c = 7; c >= 0; c--) req(3'(c), 1'(c % 2), (c == 4) ? 2'b01 : 2'b11, 1'b1);
    wait_idle();

    phase = 2;
    req(3'd1, 1'b1, 2'b10, 1'b0);
    req(3'd4, 1'b0, 2'b10, 1'b1);
    req(3'd6, 1'b1, 2'b10, 1'b0);
    wait_idle();

    chk(ridx == nreq, "R9 ignored start adds no conversion", ridx, nreq);
    chk(sidx == nreq, "R9 converter saw only accepted commands", sidx, nreq);
    chk(ready && cs_n, "R9 idle at end", {ready, cs_n}, 3);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", ridx, nreq);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule